// File: doc/BRIEF.md
# Host Control Register with Set and Clear Ports

This block holds a 32-bit host control word that software reaches through two bus addresses. A write to the set port turns on every bit whose data bit is 1, and a write to the clear port turns off every bit whose data bit is 1. Data bits that are 0 leave the matching register bits untouched. Each bit position has a fixed access type: read-only zero, set/clear, clear-only, or set with hardware self-clear. The bits drive the control outputs of a serial-bus link layer. These outputs are data byte-swap disable, PHY enhancement enable, link power status, posted-write enable and link enable.

The self-clearing bit starts a soft reset of fixed length. While that reset runs the bit reads 1 and bus writes are ignored. When the reset starts, the control bits go back to their defaults and a one-cycle FIFO flush pulse is issued. A clear-only permission bit is loaded once by a serial configuration loader through a strobe. Interlocks tie the posted-write bit and the enhancement output to the state of link enable.

Top module: `hostctl_setclr_reg`

## Requirements
- R1: After hardware reset the register holds 0 in every bit except bit 30 (value of parameter RST_SWAP) and bit 18 (value of parameter RST_POSTED), and no soft reset is in progress.
- R2: A write to SET_ADDR (default 0x50) sets each settable bit whose wdata bit is 1. A write to CLR_ADDR (default 0x54) clears each clearable bit whose wdata bit is 1. All other bits keep their values.
- R3: Bit 31, bits 29..24, bits 21..20 and bits 15..0 always read 0 and ignore writes at both ports.
- R4: Bit 23 cannot be set through the set port and can be cleared through the clear port. A one-cycle pulse on ee_load_stb loads ee_load_bit into bit 23.
- R5: If ee_load_stb arrives in the same cycle as an accepted write to either port, the bus write is applied and the load is discarded.
- R6: Bit 18 (posted-write enable) changes through a write only when bit 17 (link enable) was 0 before that write.
- R7: The outputs follow the register: byte_swap_off = bit 30, lps_en = bit 19, posted_wr_en = bit 18, link_active = bit 17, and phy_enh_en = bit 22 AND bit 23 AND bit 17.
- R8: Writing 1 to bit 16 at the set port starts a soft reset. Bit 16 then reads 1 for exactly RST_CYCLES cycles and returns to 0 by itself. At the start, bits 30, 22, 19, 18 and 17 return to their R1 values, and bit 23 keeps its value.
- R9: fifo_flush pulses high for one cycle in the first cycle of a soft reset.
- R10: Writes to either port have no effect while a soft reset is in progress.
- R11: rdata shows the register at either port address and reads 0 at any other address. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| wr_en | input | 1 | Bus write strobe |
| addr | input | ADDR_W | Bus address for reads and writes |
| wdata | input | 32 | Write data; 1 bits select the bits to set or clear |
| rdata | output | 32 | Register value when addr is a port address, else 0 |
| ee_load_stb | input | 1 | One-cycle preload strobe from the serial loader |
| ee_load_bit | input | 1 | Preload value for bit 23 |
| byte_swap_off | output | 1 | Data byte-swap disable |
| phy_enh_en | output | 1 | PHY enhancement enable, gated by bits 23 and 17 |
| lps_en | output | 1 | Link-PHY interface enable |
| posted_wr_en | output | 1 | Posted-write enable |
| link_active | output | 1 | Link enable |
| soft_reset_o | output | 1 | High while the soft reset runs |
| fifo_flush | output | 1 | One-cycle flush pulse at the start of a soft reset |

## Verification
The bench builds the block with RST_POSTED set to 1 and RST_CYCLES set to 6. With RST_POSTED at 1, the posted-write default is distinct from a cleared bit, so the bench can see that a soft reset really reloads the defaults and does not just zero the register. With RST_CYCLES at 6, the bench can count every cycle of the reset window. It can also place a bus write inside that window and an eeprom strobe on top of a bus write, with the interlocks checked on both sides of link enable.

// File: rtl/scr_pkg.sv
// Shared definitions for the set/clear host control register.
// Assumes a 32-bit register word with fixed bit positions.
package scr_pkg;

    typedef enum logic [1:0] {
        ACC_RO,    // reads zero, ignores writes
        ACC_RSC,   // set and clear through the two ports
        ACC_RC,    // clear-only from the bus, loaded by the serial loader
        ACC_RSCU   // set by the bus, cleared by hardware
    } acc_e;

    localparam int unsigned B_SWAP  = 30;
    localparam int unsigned B_PERM  = 23;
    localparam int unsigned B_ENH   = 22;
    localparam int unsigned B_LPS   = 19;
    localparam int unsigned B_POST  = 18;
    localparam int unsigned B_LINK  = 17;
    localparam int unsigned B_SRST  = 16;

    // Access type of each bit position.
    function automatic acc_e acc_of(input int unsigned idx);
        case (idx)
            B_SWAP, B_ENH, B_LPS, B_POST, B_LINK: return ACC_RSC;
            B_PERM:                               return ACC_RC;
            B_SRST:                               return ACC_RSCU;
            default:                              return ACC_RO;
        endcase
    endfunction

endpackage

// File: rtl/scr_addr_decode.sv
// Decodes the set and clear port addresses.
// Assumes the two addresses differ.
module scr_addr_decode #(
    parameter int unsigned ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] SET_ADDR = 8'h50,
    parameter logic [ADDR_W-1:0] CLR_ADDR = 8'h54
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              set_hit,
    output logic              clr_hit,
    output logic              any_hit
);

    // Compare the address against both port addresses.
    always_comb begin
        set_hit = (addr == SET_ADDR);
        clr_hit = (addr == CLR_ADDR);
        any_hit = set_hit | clr_hit;
    end

endmodule

// File: rtl/scr_srst_seq.sv
// Soft reset sequencer. A start pulse opens a window of CYCLES clocks
// and emits a one-cycle flush pulse. Assumes start is only raised
// while idle.
module scr_srst_seq #(
    parameter int unsigned CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic flush
);

    localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] remain;

    // Count down the reset window and drive the flush pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
            flush  <= 1'b0;
        end else begin
            flush <= start;
            if (start) begin
                busy   <= 1'b1;
                remain <= LAST;
            end else if (busy) begin
                if (remain == '0) busy <= 1'b0;
                else              remain <= remain - 1'b1;
            end
        end
    end

endmodule

// File: rtl/scr_bit_cell.sv
// One storage bit of the control word. Priority: reinit, set, clear,
// preload. Assumes set and clear are never raised together.
module scr_bit_cell #(
    parameter bit CAN_SET = 1'b1,
    parameter bit CAN_CLR = 1'b1,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reinit,
    input  logic set_stb,
    input  logic clr_stb,
    input  logic wr_gate,
    input  logic pre_en,
    input  logic pre_val,
    output logic q
);

    // Update the bit from reset, bus strobes or preload.
    always_ff @(posedge clk) begin
        if (!rst_n)                          q <= RST_VAL;
        else if (reinit)                     q <= RST_VAL;
        else if (CAN_SET && wr_gate && set_stb) q <= 1'b1;
        else if (CAN_CLR && wr_gate && clr_stb) q <= 1'b0;
        else if (pre_en)                     q <= pre_val;
    end

endmodule

// File: rtl/hostctl_setclr_reg.sv
// Host control register with separate set and clear ports, per-bit
// access types, a timed soft reset and a one-shot preload of the
// permission bit. Assumes a single bus master with one write per cycle.
module hostctl_setclr_reg
    import scr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] SET_ADDR = 8'h50,
    parameter logic [ADDR_W-1:0] CLR_ADDR = 8'h54,
    parameter int unsigned RST_CYCLES = 16,
    parameter bit          RST_SWAP   = 1'b0,
    parameter bit          RST_POSTED = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              ee_load_stb,
    input  logic              ee_load_bit,
    output logic              byte_swap_off,
    output logic              phy_enh_en,
    output logic              lps_en,
    output logic              posted_wr_en,
    output logic              link_active,
    output logic              soft_reset_o,
    output logic              fifo_flush
);

    localparam logic [31:0] RST_WORD =
        (32'(RST_SWAP) << B_SWAP) | (32'(RST_POSTED) << B_POST);

    logic [31:0] regv;
    logic        set_hit, clr_hit, any_hit;
    logic        accept, srst_start, srst_busy, ee_take;
    logic [31:0] ro_mask;
    logic        unused_wbits;

    scr_addr_decode #(
        .ADDR_W  (ADDR_W),
        .SET_ADDR(SET_ADDR),
        .CLR_ADDR(CLR_ADDR)
    ) u_dec (
        .addr   (addr),
        .set_hit(set_hit),
        .clr_hit(clr_hit),
        .any_hit(any_hit)
    );

    // Accept bus writes only when idle; drop a preload that collides with one.
    always_comb begin
        accept     = wr_en & ~srst_busy;
        srst_start = accept & set_hit & wdata[B_SRST];
        ee_take    = ee_load_stb & ~(accept & any_hit);
    end

    scr_srst_seq #(.CYCLES(RST_CYCLES)) u_seq (
        .clk  (clk),
        .rst_n(rst_n),
        .start(srst_start),
        .busy (srst_busy),
        .flush(fifo_flush)
    );

    for (genvar i = 0; i < 32; i++) begin : g_bit
        if (acc_of(i) == ACC_RSC || acc_of(i) == ACC_RC) begin : g_cell
            scr_bit_cell #(
                .CAN_SET(acc_of(i) == ACC_RSC),
                .CAN_CLR(1'b1),
                .RST_VAL(RST_WORD[i])
            ) u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .reinit ((i == B_PERM) ? 1'b0 : srst_start),
                .set_stb(accept & set_hit & wdata[i]),
                .clr_stb(accept & clr_hit & wdata[i]),
                .wr_gate((i == B_POST) ? ~regv[B_LINK] : 1'b1),
                .pre_en ((i == B_PERM) ? ee_take : 1'b0),
                .pre_val(ee_load_bit),
                .q      (regv[i])
            );
            assign ro_mask[i] = 1'b0;
        end else if (acc_of(i) == ACC_RSCU) begin : g_self
            assign regv[i]    = srst_busy;
            assign ro_mask[i] = 1'b0;
        end else begin : g_zero
            assign regv[i]    = 1'b0;
            assign ro_mask[i] = 1'b1;
        end
    end

    assign unused_wbits = ^(wdata & ro_mask);

    // Drive the read port and the control outputs from the register.
    always_comb begin
        rdata         = any_hit ? regv : 32'h0;
        byte_swap_off = regv[B_SWAP];
        lps_en        = regv[B_LPS];
        posted_wr_en  = regv[B_POST];
        link_active   = regv[B_LINK];
        phy_enh_en    = regv[B_ENH] & regv[B_PERM] & regv[B_LINK];
        soft_reset_o  = srst_busy;
    end

endmodule

// File: rtl/scr_ctl_checker.sv
// Temporal checks on the control outputs, bound into the top module.
// Assumes the top-level port names of hostctl_setclr_reg.
module scr_ctl_checker #(
    parameter int unsigned RST_CYCLES = 16
) (
    input logic clk,
    input logic rst_n,
    input logic link_active,
    input logic phy_enh_en,
    input logic posted_wr_en,
    input logic lps_en,
    input logic soft_reset_o,
    input logic fifo_flush
);

    localparam int unsigned W = $clog2(RST_CYCLES + 2);
    logic [W-1:0] run_len;

    // Measure how long the soft reset window stays open.
    always_ff @(posedge clk) begin
        if (!rst_n)            run_len <= '0;
        else if (soft_reset_o) run_len <= run_len + 1'b1;
        else                   run_len <= '0;
    end

    p_enh_needs_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
        phy_enh_en |-> link_active);

    p_posted_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        link_active |=> ($stable(posted_wr_en) || $rose(soft_reset_o)));

    p_srst_drops_link_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(soft_reset_o) |-> !link_active);

    p_srst_length_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(soft_reset_o) |-> (run_len == W'(RST_CYCLES)));

    p_flush_in_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |-> $rose(soft_reset_o));

    p_busy_blocks_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset_o |=> $stable(lps_en));

endmodule

bind hostctl_setclr_reg scr_ctl_checker #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .link_active (link_active),
    .phy_enh_en  (phy_enh_en),
    .posted_wr_en(posted_wr_en),
    .lps_en      (lps_en),
    .soft_reset_o(soft_reset_o),
    .fifo_flush  (fifo_flush)
);

// File: tb/tb_hostctl_setclr_reg.sv
module tb_hostctl_setclr_reg;

    localparam int unsigned NCYC = 6;
    localparam logic [7:0] A_SET = 8'h50;
    localparam logic [7:0] A_CLR = 8'h54;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = A_SET;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ee_load_stb = 1'b0, ee_load_bit = 1'b0;
    logic        byte_swap_off, phy_enh_en, lps_en, posted_wr_en;
    logic        link_active, soft_reset_o, fifo_flush;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    hostctl_setclr_reg #(
        .RST_CYCLES(NCYC),
        .RST_POSTED(1'b1)
    ) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ee_load_stb(ee_load_stb),
        .ee_load_bit(ee_load_bit), .byte_swap_off(byte_swap_off),
        .phy_enh_en(phy_enh_en), .lps_en(lps_en),
        .posted_wr_en(posted_wr_en), .link_active(link_active),
        .soft_reset_o(soft_reset_o), .fifo_flush(fifo_flush)
    );

    task automatic check(input string req, input logic [31:0] got,
                         input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One write cycle; returns at the negedge after the capturing edge.
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = A_SET; wdata = '0;
        #1;
    endtask

    task automatic ee_load(input logic v);
        @(negedge clk);
        ee_load_stb = 1'b1; ee_load_bit = v;
        @(negedge clk);
        ee_load_stb = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        addr = A_SET; #1;
        check("R1 reset word", rdata, 32'h0004_0000);
        check("R1 no soft reset", {31'b0, soft_reset_o}, 32'h0);
        check("R7 posted out at reset", {31'b0, posted_wr_en}, 32'h1);
    endtask

    task automatic t_set_clear;
        bus_write(A_SET, 32'h4008_0000);
        check("R2 set bits 30,19", rdata, 32'h400C_0000);
        check("R7 swap/lps outputs", {30'b0, byte_swap_off, lps_en}, 32'h3);
        bus_write(A_CLR, 32'h4000_0000);
        check("R2 clear bit 30", rdata, 32'h000C_0000);
    endtask

    task automatic t_reserved;
        bus_write(A_SET, 32'hBF30_FFFF);
        check("R3 reserved set ignored", rdata, 32'h000C_0000);
        bus_write(A_CLR, 32'hBF30_FFFF);
        check("R3 reserved clear ignored", rdata, 32'h000C_0000);
    endtask

    task automatic t_perm_bit;
        bus_write(A_SET, 32'h0080_0000);
        check("R4 bit23 not settable", rdata, 32'h000C_0000);
        ee_load(1'b1);
        check("R4 preload bit23", rdata, 32'h008C_0000);
        bus_write(A_CLR, 32'h0080_0000);
        check("R4 clear bit23", rdata, 32'h000C_0000);
        ee_load(1'b1);
    endtask

    task automatic t_priority;
        @(negedge clk);
        wr_en = 1'b1; addr = A_CLR; wdata = 32'h0008_0000;
        ee_load_stb = 1'b1; ee_load_bit = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; ee_load_stb = 1'b0; addr = A_SET; wdata = '0;
        #1;
        check("R5 write wins over preload", rdata, 32'h0084_0000);
    endtask

    task automatic t_posted;
        bus_write(A_CLR, 32'h0004_0000);
        check("R6 posted clear while link off", {31'b0, posted_wr_en}, 32'h0);
        bus_write(A_SET, 32'h0002_0000);
        bus_write(A_SET, 32'h0004_0000);
        check("R6 posted set blocked by link", {31'b0, posted_wr_en}, 32'h0);
        bus_write(A_CLR, 32'h0002_0000);
        bus_write(A_SET, 32'h0004_0000);
        check("R6 posted set after link off", {31'b0, posted_wr_en}, 32'h1);
    endtask

    task automatic t_enh;
        bus_write(A_SET, 32'h0040_0000);
        check("R7 enh gated by link", {31'b0, phy_enh_en}, 32'h0);
        bus_write(A_SET, 32'h0002_0000);
        check("R7 enh with link and perm", {31'b0, phy_enh_en}, 32'h1);
        bus_write(A_CLR, 32'h0080_0000);
        check("R7 enh gated by perm", {31'b0, phy_enh_en}, 32'h0);
        ee_load(1'b1);
        check("R7 link out", {31'b0, link_active}, 32'h1);
    endtask

    task automatic t_soft_reset;
        int seen = 0;
        bus_write(A_SET, 32'h4008_0000);
        bus_write(A_SET, 32'h0001_0000);
        check("R8 defaults at start", rdata, 32'h0085_0000);
        check("R9 flush first cycle", {31'b0, fifo_flush}, 32'h1);
        for (int k = 0; k < 20; k++) begin
            if (rdata[16]) seen++;
            if (k == 1) begin
                check("R9 flush one cycle", {31'b0, fifo_flush}, 32'h0);
                wr_en = 1'b1; wdata = 32'h0008_0000;
            end
            if (k == 2) begin
                wr_en = 1'b0; wdata = '0;
            end
            @(negedge clk);
            #1;
        end
        check("R8 window length", 32'(seen), 32'(NCYC));
        check("R10 write in window ignored", rdata, 32'h0084_0000);
    endtask

    task automatic t_other_addr;
        bus_write(8'h58, 32'h0008_0000);
        check("R11 other addr write ignored", rdata, 32'h0084_0000);
        addr = 8'h58; #1;
        check("R11 other addr reads zero", rdata, 32'h0);
        addr = A_CLR; #1;
        check("R11 clear addr reads word", rdata, 32'h0084_0000);
        addr = A_SET;
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_set_clear();
        t_reserved();
        t_perm_bit();
        t_priority();
        t_posted();
        t_enh();
        t_soft_reset();
        t_other_addr();
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fail);
        $finish;
    end

endmodule